// File: doc/BRIEF.md
# Two-wire serial EEPROM slave engine

This block is the slave half of a two-wire serial memory that uses 16-bit byte addresses. A fast system clock samples the bus clock and data lines. The block finds START and STOP conditions and checks the first byte after START against a fixed device type and three strap inputs. It then takes a two-byte address, high byte first, and after that either stores data bytes or sends bytes back. It never drives SDA high. It only asserts an active-high enable that pulls the line low.

A small synchronous RAM stands in for the nonvolatile array, and each accepted data byte is also presented on a one-cycle write strobe. Reads can start from the internal address counter, or from a random address loaded by a dummy write followed by a repeated START. A read continues byte after byte while the master acknowledges, and the counter wraps across the whole array. A write-control input refuses data bytes. A busy input makes the block ignore the bus completely while an external write cycle runs.

Top module: `eeprom_slave`

## Requirements
- R1: After reset, `sda_pull_o` is 0 and `wr_en_o` is 0.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START in any state drops the transfer in progress and starts receiving a new device select byte.
- R3: The first byte after START arrives MSB first. The block acknowledges it, by pulling SDA low during the 9th clock, only when bits 7..4 are 1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 is R/W, with 1 meaning read. On a mismatch the block gives no acknowledge and ignores the bus until the next START.
- R4: In a write (R/W=0), the block acknowledges both address bytes, high byte first, and uses only the low ADDR_W bits of the address. It acknowledges each data byte, stores it at the counter address, pulses `wr_en_o` with that address and data, and then increments the counter.
- R5: While `wc_i` is 1, the device select and address bytes are still acknowledged. Every data byte gets NoAck, and neither the array nor `wr_en_o` changes.
- R6: A random read is a dummy write of the address, then a repeated START and a device select with R/W=1. It returns the byte at that address, and `wc_i` has no effect on it.
- R7: A read that starts right after START returns the byte at the internal counter and then increments the counter.
- R8: When the master acknowledges a byte it has read, the next consecutive byte follows. After address 2^ADDR_W-1 the next byte comes from address 0.
- R9: A master NoAck ends a read. The block releases SDA and sends nothing more until the next START.
- R10: While `busy_i` is 1, the block ignores START and does not acknowledge a device select, even one that matches.
- R11: `sda_pull_o` changes only while the synchronized SCL is low, except when a START, a STOP or busy forces the line to be released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Strap value expected in device select bits 3..1 |
| wc_i | input | 1 | Write control, 1 refuses data bytes |
| busy_i | input | 1 | Internal write cycle running, bus ignored |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| wr_en_o | output | 1 | One-cycle strobe for an accepted data byte |
| wr_addr_o | output | ADDR_W | Address of the accepted data byte |
| wr_data_o | output | 8 | Accepted data byte |

## Verification
On every cycle, the assertions check four things. The pull enable only changes while SCL is low, apart from START, STOP and busy. Busy and the idle state keep the line released. A write strobe appears only in the data phase and never while write control is high. Only the bench's bus transactions can show the rest. These are the ack pattern for matching and mismatching selects, data stored at consecutive addresses, random, current and sequential reads with wrap-around, the NoAck ending a read, a START aborting a half-received byte, and the device select that goes unanswered while busy.

// File: rtl/eeprom_slave.sv
module eeprom_slave #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              wc_i,
  input  logic              busy_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_AH, ST_AL, ST_WD, ST_RD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       scl_s, sda_s;
  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  logic start_ev, stop_ev, rise_ev, fall_ev;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  assign rise_ev  = scl_s & ~scl_d;
  assign fall_ev  = ~scl_s & scl_d;

  st_t             st;
  logic [3:0]      cnt;
  logic [7:0]      sh, txsh, hi;
  logic            rd_bit, ack_ok, mack;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]      mem [DEPTH];
  logic [7:0]      rd_q;

  logic dev_match;
  assign dev_match = (sh[7:1] == {4'b1010, strap_i});

  always_ff @(posedge clk) begin
    rd_q <= mem[ptr];
    if (wr_en_o) mem[wr_addr_o] <= wr_data_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cnt <= '0;
      sh <= '0;
      txsh <= '0;
      hi <= '0;
      rd_bit <= 1'b0;
      ack_ok <= 1'b0;
      mack <= 1'b0;
      ptr <= '0;
      sda_pull_o <= 1'b0;
      wr_en_o <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (busy_i) begin
        st <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_ev) begin
        st <= ST_DEV;
        cnt <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_ev) begin
        st <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (rise_ev) begin
          if (cnt < 4'd8) sh <= {sh[6:0], sda_s};
          if (cnt == 4'd8) mack <= ~sda_s;
          if (cnt < 4'd9) cnt <= cnt + 4'd1;
        end else if (fall_ev) begin
          if (st == ST_RD) begin
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              txsh <= {txsh[6:0], 1'b0};
              sda_pull_o <= ~txsh[6];
            end else if (cnt == 4'd8) begin
              sda_pull_o <= 1'b0;
            end else if (cnt == 4'd9) begin
              if (mack) begin
                cnt <= '0;
                txsh <= rd_q;
                sda_pull_o <= ~rd_q[7];
                ptr <= ptr + 1'b1;
              end else begin
                st <= ST_IDLE;
                sda_pull_o <= 1'b0;
              end
            end
          end else if (cnt == 4'd8) begin
            case (st)
              ST_DEV: begin
                ack_ok <= dev_match;
                rd_bit <= sh[0];
                sda_pull_o <= dev_match;
                if (!dev_match) st <= ST_IDLE;
              end
              ST_AH: begin
                hi <= sh;
                ack_ok <= 1'b1;
                sda_pull_o <= 1'b1;
              end
              ST_AL: begin
                ptr <= ADDR_W'({hi, sh});
                ack_ok <= 1'b1;
                sda_pull_o <= 1'b1;
              end
              default: begin
                ack_ok <= ~wc_i;
                sda_pull_o <= ~wc_i;
                if (!wc_i) begin
                  wr_en_o <= 1'b1;
                  wr_addr_o <= ptr;
                  wr_data_o <= sh;
                  ptr <= ptr + 1'b1;
                end
              end
            endcase
          end else if (cnt == 4'd9) begin
            sda_pull_o <= 1'b0;
            cnt <= '0;
            case (st)
              ST_DEV: begin
                if (rd_bit) begin
                  st <= ST_RD;
                  txsh <= rd_q;
                  sda_pull_o <= ~rd_q[7];
                  ptr <= ptr + 1'b1;
                end else begin
                  st <= ST_AH;
                end
              end
              ST_AH: st <= ST_AL;
              ST_AL: st <= ST_WD;
              default: st <= st;
            endcase
          end
        end
      end
    end
  end

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> (!$past(scl_s) || $past(start_ev) || $past(stop_ev) || $past(busy_i))); // R11

  AST_BUSY_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> (!sda_pull_o && st == ST_IDLE)); // R10

  AST_WC_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> !$past(wc_i)); // R5

  AST_STROBE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ($past(st) == ST_WD)); // R4

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_IDLE) |-> !sda_pull_o); // R9

endmodule

// File: tb/sim_eeprom_slave.sv
module sim_eeprom_slave;
  localparam int AW = 8;
  localparam int N = 1 << AW;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_pull = 1'b0;
  logic [2:0] strap = 3'b101;
  logic wc = 1'b0;
  logic busy = 1'b0;
  logic sda_pull_o, wr_en_o;
  logic [AW-1:0] wr_addr_o;
  logic [7:0] wr_data_o;
  logic sda_bus;
  assign sda_bus = ~(m_pull | sda_pull_o);

  always #2.5 clk = ~clk;

  eeprom_slave #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
    .wc_i(wc), .busy_i(busy), .sda_pull_o(sda_pull_o), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  logic [7:0] mdl [N];

  always @(posedge clk) if (rst_n && wr_en_o) strobes <= strobes + 1;

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 37 + 11 + k * 101) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c;
    m_pull = 1'b0; hw(HP);
    scl = 1'b1; hw(HP);
    m_pull = 1'b1; hw(HP);
    scl = 1'b0; hw(HP);
  endtask

  task automatic stop_c;
    m_pull = 1'b1; hw(HP);
    scl = 1'b1; hw(HP);
    m_pull = 1'b0; hw(HP);
  endtask

  task automatic bit_c(input logic b, output logic s);
    m_pull = ~b; hw(HP);
    scl = 1'b1; hw(HP / 2);
    s = sda_bus; hw(HP / 2);
    scl = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_c(d[i], s);
    bit_c(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_c(1'b1, s);
      d[i] = s;
    end
    bit_c(~mack, s);
  endtask

  task automatic set_addr(input logic [15:0] a, input string tag);
    logic ack;
    start_c;
    wbyte({4'b1010, strap, 1'b0}, ack); chk(ack, tag, ack, 1);
    wbyte(a[15:8], ack); chk(ack, tag, ack, 1);
    wbyte(a[7:0], ack); chk(ack, tag, ack, 1);
  endtask

  logic ack;
  logic [7:0] d;
  int base;

  initial begin
    hw(5);
    chk(sda_pull_o == 1'b0 && wr_en_o == 1'b0, "R1", {sda_pull_o, wr_en_o}, 0);
    rst_n = 1'b1;
    hw(5);
    chk(sda_pull_o == 1'b0, "R1", sda_pull_o, 0);

    // R4: fill the whole array, upper address bits don't-care
    set_addr(16'hA500, "R4");
    for (int a = 0; a < N; a++) begin
      mdl[a] = pat(a, 0);
      wbyte(mdl[a], ack);
      chk(ack, "R4 data ack", ack, 1);
    end
    stop_c;
    chk(strobes == N, "R4 strobes", strobes, N);

    // R6: random read, wc high has no effect on reads
    wc = 1'b1;
    set_addr(16'h0037, "R6");
    start_c;
    wbyte({4'b1010, strap, 1'b1}, ack); chk(ack, "R6", ack, 1);
    rbyte(1'b0, d); chk(d == mdl[8'h37], "R6", d, mdl[8'h37]);
    stop_c;
    wc = 1'b0;

    // R8: sequential read across the top address wraps to 0
    set_addr(16'h00FF, "R8");
    start_c;
    wbyte({4'b1010, strap, 1'b1}, ack); chk(ack, "R8", ack, 1);
    rbyte(1'b1, d); chk(d == mdl[255], "R8", d, mdl[255]);
    rbyte(1'b1, d); chk(d == mdl[0], "R8 wrap", d, mdl[0]);
    rbyte(1'b0, d); chk(d == mdl[1], "R8", d, mdl[1]);
    stop_c;

    // R7: current-address read continues at 2, then 3
    start_c;
    wbyte({4'b1010, strap, 1'b1}, ack); chk(ack, "R7", ack, 1);
    rbyte(1'b0, d); chk(d == mdl[2], "R7", d, mdl[2]);
    stop_c;
    start_c;
    wbyte({4'b1010, strap, 1'b1}, ack);
    rbyte(1'b0, d); chk(d == mdl[3], "R7 increment", d, mdl[3]);
    stop_c;

    // R3: every mismatching strap/type value is refused
    for (int v = 0; v < 128; v++) begin
      if (v[6:0] != {4'b1010, strap}) begin
        start_c;
        wbyte({v[6:0], 1'b0}, ack);
        chk(!ack, "R3 mismatch", ack, 0);
        wbyte(8'h00, ack);
        chk(!ack, "R3 standby", ack, 0);
        stop_c;
      end
    end
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      start_c;
      wbyte({4'b1010, 3'(s), 1'b1}, ack);
      chk(ack, "R3 strap match", ack, 1);
      rbyte(1'b0, d);
      stop_c;
    end
    strap = 3'b101;

    // R5: write control refuses data bytes only
    base = strobes;
    wc = 1'b1;
    set_addr(16'h0010, "R5 addr ack");
    wbyte(8'h5A, ack); chk(!ack, "R5 data nack", ack, 0);
    wbyte(8'hA5, ack); chk(!ack, "R5 data nack", ack, 0);
    stop_c;
    wc = 1'b0;
    chk(strobes == base, "R5 no strobe", strobes, base);
    set_addr(16'h0010, "R5");
    start_c;
    wbyte({4'b1010, strap, 1'b1}, ack);
    rbyte(1'b1, d); chk(d == mdl[16], "R5 unchanged", d, mdl[16]);
    rbyte(1'b0, d); chk(d == mdl[17], "R5 unchanged", d, mdl[17]);
    stop_c;

    // R10: busy ignores even a matching select
    busy = 1'b1;
    start_c;
    wbyte({4'b1010, strap, 1'b0}, ack); chk(!ack, "R10 busy", ack, 0);
    stop_c;
    busy = 1'b0;
    start_c;
    wbyte({4'b1010, strap, 1'b1}, ack); chk(ack, "R10 after busy", ack, 1);
    rbyte(1'b0, d);
    stop_c;

    // R9: after NoAck nothing is driven
    set_addr(16'h0040, "R9");
    start_c;
    wbyte({4'b1010, strap, 1'b1}, ack);
    rbyte(1'b0, d); chk(d == mdl[64], "R9", d, mdl[64]);
    rbyte(1'b0, d); chk(d == 8'hFF, "R9 released", d, 8'hFF);
    stop_c;

    // R2: START mid-byte aborts, counter unchanged (sits at 0x41)
    start_c;
    wbyte({4'b1010, strap, 1'b0}, ack);
    for (int i = 0; i < 4; i++) bit_c(1'b0, ack);
    start_c;
    wbyte({4'b1010, strap, 1'b1}, ack); chk(ack, "R2 restart", ack, 1);
    rbyte(1'b0, d); chk(d == mdl[65], "R2 abort", d, mdl[65]);
    stop_c;

    // R4/R8: rewrite with a new pattern and read the whole array back plus wrap
    set_addr(16'h0000, "R4");
    for (int a = 0; a < N; a++) begin
      mdl[a] = pat(a, 1);
      wbyte(mdl[a], ack);
      if (!ack) chk(0, "R4 data ack", ack, 1);
    end
    stop_c;
    set_addr(16'h0000, "R8");
    start_c;
    wbyte({4'b1010, strap, 1'b1}, ack);
    for (int a = 0; a <= N; a++) begin
      rbyte(a != N, d);
      if (d != mdl[a % N]) chk(0, "R8 sweep", d, mdl[a % N]);
    end
    checks++;
    stop_c;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule